// File: doc/BRIEF.md
# Seven-Level Inverter Gate Pattern Generator

This block drives the ten gate signals of one phase leg of a seven-level inverter. The leg has two stages. A level stage stacks equal DC sources to build a magnitude of 0 to 3 steps. A full bridge that switches at the fundamental frequency then sets the sign of that magnitude at the load. The block keeps a phase accumulator, stepped each clock by a tuning word. The top phase bit picks the half cycle. The remaining bits address a mirrored quarter-wave table, and that table yields a rectified sine reference scaled by a modulation index.

Three triangular carriers are compared against the rectified reference. They share one up/down counter and are stacked without overlap across full scale. The count of carriers the reference exceeds gives the level index. A fixed table maps that index to the level-stage switches. The polarity of the bridge changes only after the half-cycle bit has flipped, and only while the level index is zero. Every change of the bridge inserts a programmable gap in which all four bridge gates are off. All gates come out of registers.

Top module: `mlpwm_gate_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all ten gates go to 0 on that edge. After release, the first DEAD_CYC edges give the level-0 pattern with every bridge gate off. Edge DEAD_CYC+1 adds the forward pair.
- R2: `gate_o` bit k-1 drives switch Sk. The level-stage patterns are: level 0 = S2,S3,S4; level 1 = S2,S3,S5; level 2 = S2,S5,S6; level 3 = S1,S5. No other combination of S1..S6 ever appears.
- R3: The level index is the number of carriers that the reference strictly exceeds. Carrier k (k = 0,1,2) is k*SPAN plus a shared triangle that runs between 0 and SPAN = FS/3, where FS = 2^AMP_W-1. A zero reference always gives level 0.
- R4: Forward polarity turns on S8 and S9. Reverse polarity turns on S7 and S10. The half cycle where the phase MSB is 0 is forward, and the block starts in forward.
- R5: The polarity changes only after the phase MSB differs from the present polarity, and only while the level index is 0. The gate sample just before the bridge turns off shows the level-0 pattern. A tuning word of 0 never changes the polarity.
- R6: Between one bridge pair and the other, all four bridge gates stay off for exactly DEAD_CYC cycles.
- R7: With a tuning word T that divides 2^31, successive bridge turn-on events are 2^31/T cycles apart.
- R8: S7 and S8 are never on together, and S9 and S10 are never on together.
- R9: The reference is (table * M) >> 8, where M is the 8-bit modulation index and the table peaks near FS. M = 0 keeps level 0. M = 80 never goes above level 1, and M = 170 never goes above level 2. Over several half cycles, M = 80 reaches level 1, M = 170 reaches level 2 and M = 255 reaches level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_i | input | PHASE_W | Phase step added each cycle |
| mod_i | input | MOD_W | Modulation index, full scale 255/256 |
| gate_o | output | 10 | Gate drives, bit k-1 = switch Sk |

## Verification
Several faults show up at the ports within one sample: a corrupted level index or switch table gives an illegal S1..S6 code, and a broken bridge state gives an illegal bridge code. A dead-time counter that is off by one changes the length of the off gap, which is measured on the very next polarity change. A wrong half-cycle alignment or a wrong level-zero gate moves the spacing between turn-ons, or lets the bridge drop while a non-zero level is on the gates. A scaling fault appears as the wrong peak level within a few half cycles.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int N_CAR  = 3;
    localparam int GATE_N = 10;

    typedef logic [1:0] level_t;

    typedef enum logic {
        POL_FWD = 1'b0,
        POL_REV = 1'b1
    } pol_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic s4;
        logic s5;
        logic s6;
    } lvl_sw_t;

    typedef struct packed {
        logic s7;
        logic s8;
        logic s9;
        logic s10;
    } br_sw_t;

    function automatic lvl_sw_t level_switches(level_t lv);
        lvl_sw_t s;
        s = '0;
        case (lv)
            2'd0: begin s.s2 = 1'b1; s.s3 = 1'b1; s.s4 = 1'b1; end
            2'd1: begin s.s2 = 1'b1; s.s3 = 1'b1; s.s5 = 1'b1; end
            2'd2: begin s.s2 = 1'b1; s.s6 = 1'b1; s.s5 = 1'b1; end
            default: begin s.s1 = 1'b1; s.s5 = 1'b1; end
        endcase
        return s;
    endfunction

    function automatic br_sw_t bridge_switches(pol_e p, logic conduct);
        br_sw_t b;
        b = '0;
        if (conduct) begin
            if (p == POL_FWD) begin
                b.s8 = 1'b1;
                b.s9 = 1'b1;
            end else begin
                b.s7  = 1'b1;
                b.s10 = 1'b1;
            end
        end
        return b;
    endfunction

    function automatic logic [GATE_N-1:0] pack_gates(lvl_sw_t l, br_sw_t b);
        logic [GATE_N-1:0] g;
        g[0] = l.s1;
        g[1] = l.s2;
        g[2] = l.s3;
        g[3] = l.s4;
        g[4] = l.s5;
        g[5] = l.s6;
        g[6] = b.s7;
        g[7] = b.s8;
        g[8] = b.s9;
        g[9] = b.s10;
        return g;
    endfunction

    // Rational sine approximation over a half wave: point idx of 2*depth.
    function automatic int sine_point(int idx, int depth, int fs);
        longint p;
        longint n;
        longint num;
        longint den;
        p   = longint'(idx);
        n   = 2 * longint'(depth);
        num = 16 * p * (n - p);
        den = 5 * n * n - 4 * p * (n - p);
        return int'((longint'(fs) * num) / den);
    endfunction

endpackage

// File: rtl/mlpwm_ref_gen.sv
module mlpwm_ref_gen
    import mlpwm_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 8,
    parameter int AMP_W   = 12,
    parameter int MOD_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tune_i,
    input  logic [MOD_W-1:0]   mod_i,
    output logic [AMP_W-1:0]   ref_o,
    output logic               half_o
);

    localparam int LUT_N = 1 << LUT_AW;
    localparam int FS    = (1 << AMP_W) - 1;
    localparam int PW    = AMP_W + MOD_W;

    logic [PHASE_W-1:0] phase_q;
    logic [LUT_AW-1:0]  idx_raw;
    logic [LUT_AW-1:0]  idx;
    logic [AMP_W-1:0]   lut_rom [LUT_N];
    logic [AMP_W-1:0]   lut_q;
    logic               half1_q;
    logic [PW-1:0]      prod;
    logic [AMP_W-1:0]   ref_q;
    logic               half2_q;

    for (genvar g = 0; g < LUT_N; g++) begin : g_rom
        assign lut_rom[g] = AMP_W'(sine_point(g, LUT_N, FS));
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + tune_i;
    end

    assign idx_raw = phase_q[PHASE_W-3 -: LUT_AW];
    assign idx     = phase_q[PHASE_W-2] ? ~idx_raw : idx_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            lut_q   <= '0;
            half1_q <= 1'b0;
        end else begin
            lut_q   <= lut_rom[idx];
            half1_q <= phase_q[PHASE_W-1];
        end
    end

    assign prod = {{MOD_W{1'b0}}, lut_q} * {{AMP_W{1'b0}}, mod_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= '0;
            half2_q <= 1'b0;
        end else begin
            ref_q   <= prod[PW-1 -: AMP_W];
            half2_q <= half1_q;
        end
    end

    assign ref_o  = ref_q;
    assign half_o = half2_q;

    AST_ZERO_INDEX_ZERO_REF: assert property (@(posedge clk) disable iff (rst)
        (mod_i == '0) |=> (ref_q == '0)) else $error("zero index gave nonzero reference"); // R9

endmodule

// File: rtl/mlpwm_level.sv
module mlpwm_level
    import mlpwm_pkg::*;
#(
    parameter int AMP_W        = 12,
    parameter int CAR_PRESCALE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AMP_W-1:0] ref_i,
    input  logic             half_i,
    output level_t           level_o,
    output logic             half_o
);

    localparam int FS   = (1 << AMP_W) - 1;
    localparam int SPAN = FS / N_CAR;

    logic             step;
    logic [AMP_W-1:0] tri_q;
    logic             tri_up_q;
    logic [N_CAR-1:0] above;
    level_t           lvl_sum;
    level_t           level_q;
    logic             half_q;

    if (CAR_PRESCALE > 1) begin : g_presc
        localparam int PRW = $clog2(CAR_PRESCALE);
        logic [PRW-1:0] pre_q;
        always_ff @(posedge clk) begin
            if (rst)                                  pre_q <= '0;
            else if (pre_q == PRW'(CAR_PRESCALE - 1)) pre_q <= '0;
            else                                      pre_q <= pre_q + 1'b1;
        end
        assign step = (pre_q == PRW'(CAR_PRESCALE - 1));
    end else begin : g_nopresc
        assign step = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tri_q    <= '0;
            tri_up_q <= 1'b1;
        end else if (step) begin
            if (tri_up_q) begin
                if (tri_q == AMP_W'(SPAN)) begin
                    tri_up_q <= 1'b0;
                    tri_q    <= tri_q - 1'b1;
                end else begin
                    tri_q <= tri_q + 1'b1;
                end
            end else begin
                if (tri_q == '0) begin
                    tri_up_q <= 1'b1;
                    tri_q    <= tri_q + 1'b1;
                end else begin
                    tri_q <= tri_q - 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < N_CAR; k++) begin : g_car
        logic [AMP_W-1:0] car;
        assign car      = AMP_W'(k * SPAN) + tri_q;
        assign above[k] = (ref_i > car);
    end

    always_comb begin
        lvl_sum = '0;
        for (int k = 0; k < N_CAR; k++) begin
            lvl_sum = lvl_sum + level_t'(above[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            half_q  <= 1'b0;
        end else begin
            level_q <= lvl_sum;
            half_q  <= half_i;
        end
    end

    assign level_o = level_q;
    assign half_o  = half_q;

    AST_TRI_BOUND: assert property (@(posedge clk) disable iff (rst)
        tri_q <= AMP_W'(SPAN)) else $error("triangle beyond its span"); // R3
    AST_TRI_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tri_q != $past(tri_q)) |-> ((tri_q == $past(tri_q) + 1'b1) || (tri_q == $past(tri_q) - 1'b1)))
        else $error("triangle jumped"); // R3
    AST_ZERO_REF_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ref_i == '0) |=> (level_q == '0)) else $error("zero reference gave a level"); // R3

endmodule

// File: rtl/mlpwm_bridge.sv
module mlpwm_bridge
    import mlpwm_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  level_t level_i,
    input  logic   half_i,
    output pol_e   pol_o,
    output logic   conduct_o
);

    localparam int DW = $clog2(DEAD_CYC + 1);

    pol_e          pol_q;
    pol_e          want;
    logic [DW-1:0] dcnt_q;

    assign want = half_i ? POL_REV : POL_FWD;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= POL_FWD;
            dcnt_q <= DW'(DEAD_CYC);
        end else if (dcnt_q != '0) begin
            dcnt_q <= dcnt_q - 1'b1;
        end else if ((want != pol_q) && (level_i == '0)) begin
            pol_q  <= want;
            dcnt_q <= DW'(DEAD_CYC);
        end
    end

    assign pol_o     = pol_q;
    assign conduct_o = (dcnt_q == '0);

    AST_POL_AT_LEVEL0: assert property (@(posedge clk) disable iff (rst)
        (pol_q != $past(pol_q)) |-> ($past(level_i) == '0)) else $error("polarity moved at a nonzero level"); // R5
    AST_POL_FOLLOWS_HALF: assert property (@(posedge clk) disable iff (rst)
        (pol_q != $past(pol_q)) |-> (pol_q == ($past(half_i) ? POL_REV : POL_FWD))) else $error("polarity against half cycle"); // R5
    AST_SWITCH_OPENS: assert property (@(posedge clk) disable iff (rst)
        (pol_q != $past(pol_q)) |-> !conduct_o) else $error("bridge conducts on a polarity change"); // R6

endmodule

// File: rtl/mlpwm_gate_gen.sv
module mlpwm_gate_gen
    import mlpwm_pkg::*;
#(
    parameter int PHASE_W      = 32,
    parameter int LUT_AW       = 8,
    parameter int AMP_W        = 12,
    parameter int MOD_W        = 8,
    parameter int DEAD_CYC     = 8,
    parameter int CAR_PRESCALE = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tune_i,
    input  logic [MOD_W-1:0]   mod_i,
    output logic [9:0]         gate_o
);

    logic [AMP_W-1:0]  ref_w;
    logic              half_ref;
    level_t            level_w;
    logic              half_lvl;
    pol_e              pol_w;
    logic              conduct_w;
    logic [GATE_N-1:0] gate_d;
    logic [GATE_N-1:0] gate_q;

    mlpwm_ref_gen #(
        .PHASE_W (PHASE_W),
        .LUT_AW  (LUT_AW),
        .AMP_W   (AMP_W),
        .MOD_W   (MOD_W)
    ) i_ref (
        .clk    (clk),
        .rst    (rst),
        .tune_i (tune_i),
        .mod_i  (mod_i),
        .ref_o  (ref_w),
        .half_o (half_ref)
    );

    mlpwm_level #(
        .AMP_W        (AMP_W),
        .CAR_PRESCALE (CAR_PRESCALE)
    ) i_level (
        .clk     (clk),
        .rst     (rst),
        .ref_i   (ref_w),
        .half_i  (half_ref),
        .level_o (level_w),
        .half_o  (half_lvl)
    );

    mlpwm_bridge #(
        .DEAD_CYC (DEAD_CYC)
    ) i_bridge (
        .clk       (clk),
        .rst       (rst),
        .level_i   (level_w),
        .half_i    (half_lvl),
        .pol_o     (pol_w),
        .conduct_o (conduct_w)
    );

    assign gate_d = pack_gates(level_switches(level_w), bridge_switches(pol_w, conduct_w));

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= gate_d;
    end

    assign gate_o = gate_q;

    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(gate_q[6] && gate_q[7])) else $error("S7 and S8 both on"); // R8
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(gate_q[8] && gate_q[9])) else $error("S9 and S10 both on"); // R8
    AST_TOP_NOT_LOW: assert property (@(posedge clk) disable iff (rst)
        !(gate_q[0] && gate_q[1])) else $error("S1 with S2"); // R2
    AST_S5_NOT_S4: assert property (@(posedge clk) disable iff (rst)
        !(gate_q[4] && gate_q[3])) else $error("S5 with S4"); // R2
    AST_REV_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_q[6]) |-> ($past(gate_q[9:6]) == 4'b0000)) else $error("reverse pair without gap"); // R6
    AST_FWD_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_q[7]) |-> ($past(gate_q[9:6]) == 4'b0000)) else $error("forward pair without gap"); // R6

endmodule

// File: tb/test_mlpwm_gate_gen.sv
module test_mlpwm_gate_gen;

    localparam int DEAD = 8;
    localparam logic [9:0] PAT_L0 = 10'h00E;
    localparam logic [9:0] BR_FWD = 10'h180;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tune = '0;
    logic [7:0]  mod = '0;
    logic [9:0]  gate;

    mlpwm_gate_gen #(.DEAD_CYC(DEAD)) i_mlpwm_gate_gen (
        .clk    (clk),
        .rst    (rst),
        .tune_i (tune),
        .mod_i  (mod),
        .gate_o (gate)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit rev;
        int gap;
        int interval;
    } ev_t;

    ev_t exp_q[$];
    int  total = 0;
    int  bad = 0;
    bit  mon_en = 1'b0;
    int  max_allowed = 3;
    int  max_seen = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // R2 codes on gate[5:0]
    function automatic int decode_level(logic [5:0] l);
        case (l)
            6'b001110: return 0;
            6'b010110: return 1;
            6'b110010: return 2;
            6'b010001: return 3;
            default:   return -1;
        endcase
    endfunction

    // monitor: pops expected polarity events as the bridge turns on
    int         cyc = 0;
    int         off_cnt = 0;
    int         last_on = -1;
    logic [3:0] prev_br = '0;
    int         prev_lvl = 0;

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; off_cnt = 0; last_on = -1; prev_br = '0; prev_lvl = 0; max_seen = 0;
        end else if (mon_en) begin
            int   lvl;
            logic [3:0] br;
            ev_t  e;
            cyc++;
            lvl = decode_level(gate[5:0]);
            br  = gate[9:6];
            check(lvl >= 0, "R2", "level pattern code", int'(gate[5:0]), 14);
            check(br == 4'b0000 || br == 4'b0110 || br == 4'b1001, "R8", "bridge code", int'(br), 6);
            if (lvl > max_seen) max_seen = lvl;
            check(lvl <= max_allowed, "R9", "level above cap", lvl, max_allowed);
            if (br == 4'b0000) begin
                if (prev_br != 4'b0000)
                    check(prev_lvl == 0, "R5", "level before bridge opened", prev_lvl, 0);
                off_cnt++;
            end else if (prev_br == 4'b0000) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected polarity event", cyc, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(br == (e.rev ? 4'b1001 : 4'b0110), "R4", "pair after gap", int'(br), e.rev ? 9 : 6);
                    check(off_cnt == e.gap, "R6", "dead gap length", off_cnt, e.gap);
                    if (e.interval > 0 && last_on >= 0)
                        check(cyc - last_on == e.interval, "R7", "turn-on spacing", cyc - last_on, e.interval);
                end
                last_on = cyc;
                off_cnt = 0;
            end
            prev_br  = br;
            prev_lvl = lvl;
        end
    end

    task automatic run_case(input logic [31:0] t, input logic [7:0] m, input int halves,
                            input int cap, input int want, input string req);
        ev_t e;
        int  hp;
        int  wait_cyc;
        @(posedge clk); #1;
        mon_en = 1'b0;
        rst = 1'b1;
        tune = t;
        mod = m;
        max_allowed = cap;
        repeat (3) @(posedge clk);
        hp = (t == 0) ? 0 : int'(64'h8000_0000 / 64'(t));
        e.rev = 1'b0; e.gap = DEAD; e.interval = -1;
        exp_q.push_back(e);
        for (int h = 1; h <= halves; h++) begin
            e.rev = h[0]; e.gap = DEAD; e.interval = (h == 1) ? -1 : hp;
            exp_q.push_back(e);
        end
        wait_cyc = (t == 0) ? 3000 : halves * hp + DEAD + 100;
        #1 rst = 1'b0;
        @(posedge clk); #1 mon_en = 1'b1;
        repeat (wait_cyc) @(posedge clk);
        #1 mon_en = 1'b0;
        check(exp_q.size() == 0, "R7", {req, " events left"}, exp_q.size(), 0);
        check(max_seen == want, "R9", {req, " peak level"}, max_seen, want);
        exp_q.delete();
    endtask

    initial begin
        rst = 1'b1;
        tune = '0;
        mod = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(gate == 10'h000, "R1", "gates in reset", int'(gate), 0);
        @(posedge clk); #1 rst = 1'b0;
        for (int k = 1; k <= DEAD + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k <= DEAD)
                check(gate == PAT_L0, "R1", "startup gap pattern", int'(gate), int'(PAT_L0));
            else
                check(gate == (PAT_L0 | BR_FWD), "R1", "startup forward", int'(gate), int'(PAT_L0 | BR_FWD));
        end
        repeat (50) @(posedge clk);
        @(negedge clk);
        check(gate == (PAT_L0 | BR_FWD), "R4", "forward held", int'(gate), int'(PAT_L0 | BR_FWD));

        run_case(32'h0,         8'd255, 0, 3, 0, "R5 frozen phase");
        run_case(32'h0020_0000, 8'd0,   4, 0, 0, "R9 zero index");
        run_case(32'h0020_0000, 8'd80,  6, 1, 1, "R9 index 80");
        run_case(32'h0020_0000, 8'd170, 6, 2, 2, "R9 index 170");
        run_case(32'h0020_0000, 8'd255, 6, 3, 3, "R3 full index");
        run_case(32'h0040_0000, 8'd255, 6, 3, 3, "R7 faster phase");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule